// File: doc/BRIEF.md
# Transmit Credit Gate Per Channel

This block sits on the transmit side of a serial packet link and decides whether each outgoing packet may leave now. It keeps header and data credit pools for three traffic classes (posted, non-posted, completion) on each of two virtual channels. That makes six pools per channel. During link start-up the receiver's advertised buffer sizes are loaded into the pools. After start-up, each granted packet draws one header credit and one data credit per dword of payload from its own pool pair. Credit-update events from the link layer refill the pools.

A requester presents a class, a channel and a payload length with a valid/ready handshake. The ready output looks only at the pool pair that the request addresses. A shortage in one class or channel therefore never holds back traffic in another. The block outputs every pool's current count and a nonzero flag for each pool. It also has a saturating per-channel counter of the cycles in which a request waited for credits.

Top module: `tx_credit_gate`

## Requirements
- R1: After reset every header and data count is zero, every availability flag is low, every stall counter is zero and `req_ready` is low.
- R2: While `init_done` has not yet been seen, an `adv_valid` cycle loads `adv_hdr` and `adv_data` into the pools of class `adv_cls` on channel `adv_vc`. Once initialization has completed, `adv_valid` has no effect.
- R3: `req_ready` stays low until the clock edge at which `init_done` is first sampled high. From the next cycle on, grants are possible.
- R4: Class codes are 0 posted, 1 non-posted and 2 completion. A grant (`req_valid` and `req_ready`) subtracts 1 from the header count and `req_len` from the data count of the addressed class and channel on that clock edge. A read with length 0 takes only the header credit.
- R5: `req_ready` is low when the addressed header count is zero or the addressed data count is below `req_len`. A held request changes no count. After initialization, each such held cycle increments that channel's stall counter, which saturates at its maximum.
- R6: After initialization, an update adds `upd_hdr` and `upd_data` only to the pools of class `upd_cls` on channel `upd_vc`. A zero field leaves its pool unchanged, and all other pools keep their values.
- R7: When an update and a grant hit the same pool in one cycle, the new count is old + increment − consumption.
- R8: A request on one channel is granted or held based on that channel's pools alone, whatever the other channel's pools hold.
- R9: A count that an update would push past its maximum saturates at all ones.
- R10: Class code 3 is reserved. Such a request is never granted and never counted as a stall.
- R11: The availability flag of a pool is high exactly when its count is nonzero. The flag for header pool p is at bit 2p and the flag for data pool p is at bit 2p+1, where p = channel·3 + class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_done | input | 1 | Initialization complete; latched by the block |
| adv_valid | input | 1 | Load advertised credits |
| adv_vc | input | VC_W | Channel of the advertisement |
| adv_cls | input | 2 | Class of the advertisement |
| adv_hdr | input | HDR_W | Advertised header credits |
| adv_data | input | DAT_W | Advertised data credits |
| req_valid | input | 1 | Packet request present |
| req_vc | input | VC_W | Request channel |
| req_cls | input | 2 | Request class |
| req_len | input | LEN_W | Payload length in dwords |
| req_ready | output | 1 | Credits sufficient, grant this cycle |
| upd_valid | input | 1 | Credit-update event |
| upd_vc | input | VC_W | Update channel |
| upd_cls | input | 2 | Update class |
| upd_hdr | input | HDR_W | Header credits returned |
| upd_data | input | DAT_W | Data credits returned |
| hdr_cnt | output | NUM_VC·3·HDR_W | Header counts, pool p at p·HDR_W |
| dat_cnt | output | NUM_VC·3·DAT_W | Data counts, pool p at p·DAT_W |
| credit_avail | output | NUM_VC·6 | Nonzero flag per pool |
| stall_cnt | output | NUM_VC·STALL_W | Held-cycle count per channel |

## Verification
The properties assume `req_vc` and `upd_vc` name an existing channel and that `init_done` is the only source of the start of normal operation. The consumption check is only applied in cycles without any update, so that a refill on another pool cannot hide a wrong subtraction. The stimulus drives channel numbers 0 and 1 only. It issues advertisements only before `init_done` except for one deliberate late attempt. It overlaps an update with a grant only where R7 is being exercised.

// File: rtl/tx_credit_gate.sv
module tx_credit_gate #(
  parameter int NUM_VC  = 2,
  parameter int HDR_W   = 8,
  parameter int DAT_W   = 12,
  parameter int LEN_W   = 10,
  parameter int STALL_W = 16,
  localparam int VC_W   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int NPOOL  = NUM_VC * 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       init_done,
  input  logic                       adv_valid,
  input  logic [VC_W-1:0]            adv_vc,
  input  logic [1:0]                 adv_cls,
  input  logic [HDR_W-1:0]           adv_hdr,
  input  logic [DAT_W-1:0]           adv_data,
  input  logic                       req_valid,
  input  logic [VC_W-1:0]            req_vc,
  input  logic [1:0]                 req_cls,
  input  logic [LEN_W-1:0]           req_len,
  output logic                       req_ready,
  input  logic                       upd_valid,
  input  logic [VC_W-1:0]            upd_vc,
  input  logic [1:0]                 upd_cls,
  input  logic [HDR_W-1:0]           upd_hdr,
  input  logic [DAT_W-1:0]           upd_data,
  output logic [NPOOL*HDR_W-1:0]     hdr_cnt,
  output logic [NPOOL*DAT_W-1:0]     dat_cnt,
  output logic [NPOOL*2-1:0]         credit_avail,
  output logic [NUM_VC*STALL_W-1:0]  stall_cnt
);
  localparam int CW = (DAT_W > LEN_W) ? DAT_W : LEN_W;

  logic             init_ok;
  logic [HDR_W-1:0] sel_h;
  logic [DAT_W-1:0] sel_d;
  logic             addr_ok, enough, grant, hold;

  always_ff @(posedge clk)
    if (!rst_n)         init_ok <= 1'b0;
    else if (init_done) init_ok <= 1'b1;

  assign addr_ok = (req_cls != 2'd3) && (int'(req_vc) < NUM_VC);

  always_comb begin
    sel_h = '0;
    sel_d = '0;
    if (addr_ok) begin
      sel_h = hdr_cnt[(int'(req_vc) * 3 + int'(req_cls)) * HDR_W +: HDR_W];
      sel_d = dat_cnt[(int'(req_vc) * 3 + int'(req_cls)) * DAT_W +: DAT_W];
    end
  end

  assign enough    = (sel_h != '0) && (CW'(sel_d) >= CW'(req_len));
  assign req_ready = init_ok && addr_ok && enough;
  assign grant     = req_valid && req_ready;
  assign hold      = req_valid && init_ok && addr_ok && !enough;

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    for (genvar c = 0; c < 3; c++) begin : g_cls
      localparam int P = v * 3 + c;
      logic             hit_g, hit_u, hit_a;
      logic [HDR_W-1:0] hq;
      logic [DAT_W-1:0] dq;
      logic [HDR_W:0]   h_nx;
      logic [DAT_W:0]   d_nx;

      assign hit_g = grant && (req_vc == VC_W'(v)) && (req_cls == 2'(c));
      assign hit_u = upd_valid && init_ok && (upd_vc == VC_W'(v)) && (upd_cls == 2'(c));
      assign hit_a = adv_valid && !init_ok && (adv_vc == VC_W'(v)) && (adv_cls == 2'(c));

      assign h_nx = {1'b0, hq} + (hit_u ? {1'b0, upd_hdr} : '0)
                  - (hit_g ? (HDR_W+1)'(1) : '0);
      assign d_nx = {1'b0, dq} + (hit_u ? {1'b0, upd_data} : '0)
                  - (hit_g ? (DAT_W+1)'(req_len) : '0);

      always_ff @(posedge clk)
        if (!rst_n) begin
          hq <= '0;
          dq <= '0;
        end else if (hit_a) begin
          hq <= adv_hdr;
          dq <= adv_data;
        end else begin
          hq <= h_nx[HDR_W] ? '1 : h_nx[HDR_W-1:0];
          dq <= d_nx[DAT_W] ? '1 : d_nx[DAT_W-1:0];
        end

      assign hdr_cnt[P*HDR_W +: HDR_W] = hq;
      assign dat_cnt[P*DAT_W +: DAT_W] = dq;
      assign credit_avail[2*P]         = |hq;
      assign credit_avail[2*P+1]       = |dq;
    end

    logic [STALL_W-1:0] sq;
    always_ff @(posedge clk)
      if (!rst_n)
        sq <= '0;
      else if (hold && (req_vc == VC_W'(v)) && (sq != '1))
        sq <= sq + 1'b1;
    assign stall_cnt[v*STALL_W +: STALL_W] = sq;
  end
endmodule

// File: rtl/tx_credit_gate_chk.sv
module tx_credit_gate_chk #(
  parameter int NUM_VC  = 2,
  parameter int HDR_W   = 8,
  parameter int DAT_W   = 12,
  parameter int LEN_W   = 10,
  parameter int STALL_W = 16,
  localparam int VC_W   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int NPOOL  = NUM_VC * 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      init_done,
  input logic                      req_valid,
  input logic [VC_W-1:0]           req_vc,
  input logic [1:0]                req_cls,
  input logic [LEN_W-1:0]          req_len,
  input logic                      req_ready,
  input logic                      upd_valid,
  input logic [NPOOL*HDR_W-1:0]    hdr_cnt,
  input logic [NPOOL*DAT_W-1:0]    dat_cnt,
  input logic [NUM_VC*STALL_W-1:0] stall_cnt
);
  logic               seen;
  logic               p_go, p_hold;
  int                 p_pool, p_vc;
  logic [HDR_W-1:0]   p_h;
  logic [DAT_W-1:0]   p_d;
  logic [LEN_W-1:0]   p_len;
  logic [STALL_W-1:0] p_st;
  int                 cur_pool;

  assign cur_pool = int'(req_vc) * 3 + ((req_cls == 2'd3) ? 0 : int'(req_cls));

  always_ff @(posedge clk)
    if (!rst_n) begin
      seen   <= 1'b0;
      p_go   <= 1'b0;
      p_hold <= 1'b0;
      p_pool <= 0;
      p_vc   <= 0;
      p_h    <= '0;
      p_d    <= '0;
      p_len  <= '0;
      p_st   <= '0;
    end else begin
      if (init_done) seen <= 1'b1;
      p_go   <= req_valid && req_ready && !upd_valid;
      p_hold <= req_valid && !req_ready && seen && (req_cls != 2'd3)
                && (stall_cnt[int'(req_vc)*STALL_W +: STALL_W] != '1);
      p_pool <= cur_pool;
      p_vc   <= int'(req_vc);
      p_h    <= hdr_cnt[cur_pool*HDR_W +: HDR_W];
      p_d    <= dat_cnt[cur_pool*DAT_W +: DAT_W];
      p_len  <= req_len;
      p_st   <= stall_cnt[int'(req_vc)*STALL_W +: STALL_W];
    end

  a_r3_no_grant_before_init: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> !req_ready);

  a_r10_reserved_class: assert property (@(posedge clk) disable iff (!rst_n)
    (req_cls == 2'd3) |-> !req_ready);

  a_r4_consume: assert property (@(posedge clk) disable iff (!rst_n)
    p_go |-> (hdr_cnt[p_pool*HDR_W +: HDR_W] == p_h - 1'b1)
          && (dat_cnt[p_pool*DAT_W +: DAT_W] == p_d - DAT_W'(p_len)));

  a_r5_stall_step: assert property (@(posedge clk) disable iff (!rst_n)
    p_hold |-> (stall_cnt[p_vc*STALL_W +: STALL_W] == p_st + 1'b1));

  a_r6_quiet_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !upd_valid && !(req_valid && req_ready)) |=> ($stable(hdr_cnt) && $stable(dat_cnt)));
endmodule

bind tx_credit_gate tx_credit_gate_chk #(
  .NUM_VC(NUM_VC), .HDR_W(HDR_W), .DAT_W(DAT_W), .LEN_W(LEN_W), .STALL_W(STALL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .init_done(init_done), .req_valid(req_valid),
  .req_vc(req_vc), .req_cls(req_cls), .req_len(req_len), .req_ready(req_ready),
  .upd_valid(upd_valid), .hdr_cnt(hdr_cnt), .dat_cnt(dat_cnt), .stall_cnt(stall_cnt)
);

// File: tb/tx_credit_gate_tb.sv
module tx_credit_gate_tb;
  localparam int NV = 2, HW = 8, DW = 12, LW = 10, SW = 16;

  logic clk = 0, rst_n = 0;
  logic init_done = 0, adv_valid = 0, req_valid = 0, upd_valid = 0;
  logic [0:0] adv_vc = 0, req_vc = 0, upd_vc = 0;
  logic [1:0] adv_cls = 0, req_cls = 0, upd_cls = 0;
  logic [HW-1:0] adv_hdr = 0, upd_hdr = 0;
  logic [DW-1:0] adv_data = 0, upd_data = 0;
  logic [LW-1:0] req_len = 0;
  logic req_ready;
  logic [NV*3*HW-1:0] hdr_cnt;
  logic [NV*3*DW-1:0] dat_cnt;
  logic [NV*6-1:0]    credit_avail;
  logic [NV*SW-1:0]   stall_cnt;

  tx_credit_gate u_dut (.*);

  always #10 clk = ~clk;

  typedef struct { string tag; int vc; int cls; int h; int d; int st; } item_t;
  item_t sbq[$];
  int checks = 0, errors = 0;
  int mh[2][3], md[2][3], mst[2];
  bit minit = 0;
  bit finished = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void push_pool(string tag, int v, int c);
    item_t it;
    it.tag = tag; it.vc = v; it.cls = c;
    it.h = mh[v][c]; it.d = md[v][c]; it.st = mst[v];
    sbq.push_back(it);
  endfunction

  function automatic void push_all(string tag);
    for (int v = 0; v < 2; v++)
      for (int c = 0; c < 3; c++) push_pool(tag, v, c);
  endfunction

  always @(negedge clk)
    while (sbq.size() > 0) begin
      item_t it;
      int p;
      it = sbq.pop_front();
      p = it.vc * 3 + it.cls;
      chk({it.tag, " hdr"},   int'(hdr_cnt[p*HW +: HW]), it.h);
      chk({it.tag, " data"},  int'(dat_cnt[p*DW +: DW]), it.d);
      chk({it.tag, " stall"}, int'(stall_cnt[it.vc*SW +: SW]), it.st);
      chk({it.tag, " R11 avail"}, int'(credit_avail[2*p +: 2]),
          ((it.d != 0) ? 2 : 0) + ((it.h != 0) ? 1 : 0));
    end

  task automatic idle();
    @(negedge clk);
    adv_valid = 0; req_valid = 0; upd_valid = 0; init_done = 0;
  endtask

  task automatic adv(int v, int c, int h, int d);
    @(negedge clk);
    adv_valid = 1; adv_vc = v[0:0]; adv_cls = c[1:0];
    adv_hdr = HW'(h); adv_data = DW'(d);
    req_valid = 0; upd_valid = 0; init_done = 0;
    @(posedge clk);
    if (!minit) begin mh[v][c] = h; md[v][c] = d; end
  endtask

  task automatic do_init();
    @(negedge clk);
    adv_valid = 0; req_valid = 0; upd_valid = 0; init_done = 1;
    @(posedge clk);
    minit = 1;
  endtask

  task automatic step(string tag, bit rv, int v, int c, int len,
                      bit uv, int uvc, int ucls, int uh, int ud);
    bit mr;
    @(negedge clk);
    adv_valid = 0; init_done = 0;
    req_valid = rv; req_vc = v[0:0]; req_cls = c[1:0]; req_len = LW'(len);
    upd_valid = uv; upd_vc = uvc[0:0]; upd_cls = ucls[1:0];
    upd_hdr = HW'(uh); upd_data = DW'(ud);
    mr = minit && c < 3 && mh[v][c] > 0 && md[v][c] >= len;
    #2;
    if (rv) chk({tag, " ready"}, int'(req_ready), int'(mr));
    @(posedge clk);
    if (rv && mr) begin mh[v][c] -= 1; md[v][c] -= len; end
    if (rv && !mr && minit && c < 3 && mst[v] != 65535) mst[v] += 1;
    if (uv && minit) begin
      mh[uvc][ucls] = (mh[uvc][ucls] + uh > 255)  ? 255  : mh[uvc][ucls] + uh;
      md[uvc][ucls] = (md[uvc][ucls] + ud > 4095) ? 4095 : md[uvc][ucls] + ud;
    end
    push_all(tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int v = 0; v < 2; v++) begin
      mst[v] = 0;
      for (int c = 0; c < 3; c++) begin mh[v][c] = 0; md[v][c] = 0; end
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    push_all("R1 reset");
    @(negedge clk);
    req_valid = 1; req_vc = 0; req_cls = 0; req_len = 0;
    #2 chk("R1 ready after reset", int'(req_ready), 0);
    idle();

    adv(0, 0, 8, 32); adv(0, 1, 4, 0); adv(0, 2, 4, 64);
    adv(1, 0, 2, 16); adv(1, 1, 3, 0); adv(1, 2, 5, 40);
    idle(); push_all("R2 load");
    step("R3 before init", 1, 0, 0, 4, 0, 0, 0, 0, 0);
    do_init();
    adv(0, 0, 1, 1);
    idle(); push_all("R2 late adv ignored");

    step("R4 post len4",  1, 0, 0, 4,  0, 0, 0, 0, 0);
    step("R4 post len8",  1, 0, 0, 8,  0, 0, 0, 0, 0);
    step("R4 post len16", 1, 0, 0, 16, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++)
      step("R5 held short data", 1, 0, 0, 8, 0, 0, 0, 0, 0);
    step("R6 data-only update", 0, 0, 0, 0, 1, 0, 0, 0, 8);
    step("R4 resumed write", 1, 0, 0, 8, 0, 0, 0, 0, 0);

    step("R8 vc1 read while vc0 starved", 1, 1, 1, 0, 0, 0, 0, 0, 0);
    step("R4 vc1 completion", 1, 1, 2, 10, 0, 0, 0, 0, 0);
    step("R7 grant with update", 1, 1, 2, 6, 1, 1, 2, 2, 5);

    step("R5 drain hdr a", 1, 1, 0, 0, 0, 0, 0, 0, 0);
    step("R5 drain hdr b", 1, 1, 0, 0, 0, 0, 0, 0, 0);
    step("R5 held no hdr", 1, 1, 0, 0, 0, 0, 0, 0, 0);

    step("R9 saturate", 0, 0, 0, 0, 1, 0, 2, 255, 4095);
    step("R10 reserved class", 1, 0, 3, 0, 0, 0, 0, 0, 0);
    idle(); idle();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule